// File: doc/BRIEF.md
# Reaction Time Tester Controller

This block runs a complete reaction-time game in hardware. A free-running divider turns the system clock into a millisecond tick. Each round starts by stepping a 16-bit pseudo-random generator and reducing its value to a wait length. After that wait an LED turns on, and the block counts whole milliseconds until the player presses a button. A press that comes too early, or no press at all within the allowed window, is reported as its own outcome.

Every outcome leaves the block as a 2-bit code and a 16-bit millisecond value on a valid/ready result port. The result stays there until the consumer accepts it. After acceptance the block pauses for a fixed time and then begins the next round. The button input is active low and already debounced and synchronised; only its falling edges count as presses.

Top module: `reaction_tester`

## Requirements
- R1: One millisecond equals PRESCALE*DIVIDE clock cycles (defaults 64 and 250, giving 1 ms at 16 MHz). Every timed phase restarts the divider, so a count of N ms is reached exactly N*PRESCALE*DIVIDE cycles after the phase begins.
- R2: The random source is a 16-bit right-shifting Galois LFSR. Reset loads it with 0xBEEF. Each step shifts it right by one, and if the bit shifted out was 1 the result is XORed with 0xB400. It steps exactly once per round, before the wait is computed.
- R3: The wait length is MIN_MS + (LFSR mod SPAN_MS) ms, which is 1000 to 5000 ms by default. The LED turns on once that many milliseconds have elapsed in the wait without a press.
- R4: A falling edge on button_ni during the wait is a false start. The LED stays off and the result is code 2'b01 with the whole milliseconds already elapsed in the wait.
- R5: A falling edge while the LED is on turns the LED off. The result is code 2'b00 with the whole milliseconds elapsed since the LED turned on.
- R6: If TIMEOUT_MS ms (default 3000) pass after the LED turns on with no press, the LED turns off and the result is code 2'b10 with value TIMEOUT_MS, one cycle after the count reaches the limit.
- R7: A press in the same cycle that the timeout is judged takes priority. It is reported as code 2'b00 with value TIMEOUT_MS.
- R8: res_valid_o stays high, and res_code_o and res_ms_o stay constant, until res_ready_i is high. Button presses while a result is pending change nothing, and the LED is off whenever res_valid_o is high.
- R9: Once a result is accepted, the block waits PAUSE_MS ms (default 2000) before stepping the LFSR for the next round. Presses during the pause are ignored.
- R10: While reset is asserted, led_o and res_valid_o are low. After reset the first round starts at once, with no pause.
- R11: Only a falling edge counts as a press. A button held low from the pause through the LED turning on causes neither a false start nor a reaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| button_ni | input | 1 | Debounced, synchronised button, low when pressed |
| led_o | output | 1 | Stimulus LED, high while the player must react |
| res_valid_o | output | 1 | A round result is pending |
| res_ready_i | input | 1 | Consumer accepts the pending result |
| res_code_o | output | 2 | Outcome: 00 reaction, 01 false start, 10 too slow |
| res_ms_o | output | 16 | Millisecond value for the outcome |

## Verification
Two events can fall in the same cycle: a falling edge of the button and the millisecond count reaching the timeout limit. The bench finds the cycle the LED rises, then drives the press so that it is sampled on exactly the edge where the count first equals TIMEOUT_MS. The expected result is a valid reaction of TIMEOUT_MS ms, not a too-slow outcome. A separate check covers the timeout alone: the too-slow result must appear exactly one cycle after the limit. Together these two checks pin down both the priority and the timing.

// File: rtl/rtt_pkg.sv
package rtt_pkg;
  typedef enum logic [2:0] {
    ST_STEP, ST_REDUCE, ST_WAIT, ST_LIVE, ST_REPORT, ST_PAUSE
  } rtt_state_e;

  typedef enum logic [1:0] {
    OUT_HIT   = 2'b00,
    OUT_EARLY = 2'b01,
    OUT_SLOW  = 2'b10
  } rtt_outcome_e;
endpackage

// File: rtl/rtt_tick_gen.sv
module rtt_tick_gen #(
  parameter int PRESCALE = 64,
  parameter int DIVIDE   = 250
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  output logic tick_o
);
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam int DW = (DIVIDE > 1) ? $clog2(DIVIDE) : 1;

  logic pre_last;
  logic div_last;

  generate
    if (PRESCALE > 1) begin : g_pre
      logic [PW-1:0] pre_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       pre_q <= '0;
        else if (clear_i)  pre_q <= '0;
        else if (pre_last) pre_q <= '0;
        else               pre_q <= pre_q + 1'b1;
      end
      assign pre_last = (pre_q == PW'(PRESCALE - 1));
    end else begin : g_pre_bypass
      assign pre_last = 1'b1;
    end

    if (DIVIDE > 1) begin : g_div
      logic [DW-1:0] div_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      div_q <= '0;
        else if (clear_i) div_q <= '0;
        else if (pre_last) begin
          if (div_last) div_q <= '0;
          else          div_q <= div_q + 1'b1;
        end
      end
      assign div_last = (div_q == DW'(DIVIDE - 1));
    end else begin : g_div_bypass
      assign div_last = 1'b1;
    end

    if (PRESCALE * DIVIDE > 1) begin : g_chk
      // R1: ticks are isolated pulses
      assert_tick_isolated_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);
    end
  endgenerate

  assign tick_o = pre_last && div_last && !clear_i;
endmodule

// File: rtl/rtt_wait_gen.sv
module rtt_wait_gen #(
  parameter int          LW      = 16,
  parameter logic [15:0] SEED    = 16'hBEEF,
  parameter logic [15:0] TAPS    = 16'hB400,
  parameter int          MIN_MS  = 1000,
  parameter int          SPAN_MS = 4001,
  parameter int          MS_W    = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  output logic            done_o,
  output logic [MS_W-1:0] wait_ms_o
);
  localparam int IW = $clog2(LW);

  logic [LW-1:0] lfsr_q, rem_q, rem_nxt, lfsr_nxt;
  logic [IW-1:0] idx_q;
  logic          busy_q;
  logic [31:0]   sub_w;

  always_comb begin
    lfsr_nxt = lfsr_q >> 1;
    if (lfsr_q[0]) lfsr_nxt = lfsr_nxt ^ TAPS[LW-1:0];
  end

  // restoring remainder: one shifted modulus per cycle, fixed LW cycles
  assign sub_w   = 32'(SPAN_MS) << idx_q;
  assign rem_nxt = ({{(32-LW){1'b0}}, rem_q} >= sub_w) ? rem_q - sub_w[LW-1:0] : rem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lfsr_q <= SEED[LW-1:0];
      rem_q  <= '0;
      idx_q  <= '0;
      busy_q <= 1'b0;
    end else if (start_i && !busy_q) begin
      lfsr_q <= lfsr_nxt;
      rem_q  <= lfsr_nxt;
      idx_q  <= IW'(LW - 1);
      busy_q <= 1'b1;
    end else if (busy_q) begin
      rem_q <= rem_nxt;
      if (idx_q == '0) busy_q <= 1'b0;
      else             idx_q  <= idx_q - 1'b1;
    end
  end

  assign done_o    = busy_q && (idx_q == '0);
  assign wait_ms_o = MS_W'(MIN_MS) + MS_W'(rem_nxt);

  // R2: generator never locks up
  assert_lfsr_live_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lfsr_q != '0);
  // R3: reduced wait lies in the legal window
  assert_wait_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (32'(wait_ms_o) >= 32'(MIN_MS)) && (32'(wait_ms_o) < 32'(MIN_MS + SPAN_MS)));
  assert_start_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_q);
endmodule

// File: rtl/rtt_result_port.sv
module rtt_result_port #(
  parameter int MS_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [1:0]      code_i,
  input  logic [MS_W-1:0] ms_i,
  input  logic            ready_i,
  output logic            valid_o,
  output logic [1:0]      code_o,
  output logic [MS_W-1:0] ms_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      code_o  <= '0;
      ms_o    <= '0;
    end else if (load_i) begin
      valid_o <= 1'b1;
      code_o  <= code_i;
      ms_o    <= ms_i;
    end else if (valid_o && ready_i) begin
      valid_o <= 1'b0;
    end
  end

  // R8: pending result is held unchanged
  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ready_i |=> valid_o && $stable(code_o) && $stable(ms_o));
  assert_no_overwrite_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> !valid_o);
endmodule

// File: rtl/reaction_tester.sv
module reaction_tester #(
  parameter int PRESCALE   = 64,
  parameter int DIVIDE     = 250,
  parameter int MIN_MS     = 1000,
  parameter int SPAN_MS    = 4001,
  parameter int TIMEOUT_MS = 3000,
  parameter int PAUSE_MS   = 2000,
  parameter int MS_W       = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            button_ni,
  output logic            led_o,
  output logic            res_valid_o,
  input  logic            res_ready_i,
  output logic [1:0]      res_code_o,
  output logic [MS_W-1:0] res_ms_o
);
  import rtt_pkg::*;

  localparam logic [MS_W-1:0] TO_LIM    = MS_W'(TIMEOUT_MS);
  localparam logic [MS_W-1:0] PAUSE_LIM = MS_W'(PAUSE_MS);

  rtt_state_e      st_q, st_d;
  logic [MS_W-1:0] ms_q, wait_q, wait_w, load_ms;
  logic            tick, phase_clr, gen_start, gen_done, load, accept;
  logic            btn_prev_q, press;
  logic [1:0]      load_code;

  rtt_tick_gen #(.PRESCALE(PRESCALE), .DIVIDE(DIVIDE)) u_tick (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(phase_clr), .tick_o(tick));

  rtt_wait_gen #(.LW(16), .SEED(16'hBEEF), .TAPS(16'hB400),
                 .MIN_MS(MIN_MS), .SPAN_MS(SPAN_MS), .MS_W(MS_W)) u_wait (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(gen_start),
    .done_o(gen_done), .wait_ms_o(wait_w));

  rtt_result_port #(.MS_W(MS_W)) u_res (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load), .code_i(load_code),
    .ms_i(load_ms), .ready_i(res_ready_i), .valid_o(res_valid_o),
    .code_o(res_code_o), .ms_o(res_ms_o));

  assign press  = btn_prev_q && !button_ni;
  assign accept = res_valid_o && res_ready_i;

  always_comb begin
    st_d      = st_q;
    phase_clr = 1'b0;
    gen_start = 1'b0;
    load      = 1'b0;
    load_code = OUT_HIT;
    load_ms   = ms_q;
    unique case (st_q)
      ST_STEP: begin
        gen_start = 1'b1;
        st_d      = ST_REDUCE;
      end
      ST_REDUCE: if (gen_done) begin
        phase_clr = 1'b1;
        st_d      = ST_WAIT;
      end
      ST_WAIT: begin
        if (press) begin
          load      = 1'b1;
          load_code = OUT_EARLY;
          st_d      = ST_REPORT;
        end else if (ms_q == wait_q) begin
          phase_clr = 1'b1;
          st_d      = ST_LIVE;
        end
      end
      ST_LIVE: begin
        if (press) begin
          load = 1'b1;
          st_d = ST_REPORT;
        end else if (ms_q == TO_LIM) begin
          load      = 1'b1;
          load_code = OUT_SLOW;
          load_ms   = TO_LIM;
          st_d      = ST_REPORT;
        end
      end
      ST_REPORT: if (accept) begin
        phase_clr = 1'b1;
        st_d      = ST_PAUSE;
      end
      ST_PAUSE: if (ms_q == PAUSE_LIM) st_d = ST_STEP;
      default: st_d = ST_STEP;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_STEP;
      ms_q       <= '0;
      wait_q     <= '0;
      btn_prev_q <= 1'b1;
    end else begin
      st_q       <= st_d;
      btn_prev_q <= button_ni;
      if (phase_clr)                  ms_q <= '0;
      else if (tick && (ms_q != '1))  ms_q <= ms_q + 1'b1;
      if (gen_done)                   wait_q <= wait_w;
    end
  end

  assign led_o = (st_q == ST_LIVE);

  // R8: LED dark while a result is pending
  assert_led_dark_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> !led_o);
  // R6: live count never passes the timeout
  assert_live_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_LIVE) |-> ms_q <= TO_LIM);
  // R3: wait count never passes the drawn length
  assert_wait_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WAIT) |-> ms_q <= wait_q);
  // R9: pause count never passes its limit
  assert_pause_bound_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_PAUSE) |-> ms_q <= PAUSE_LIM);
  // R4: a false start never lights the LED
  assert_early_dark_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WAIT) && press |=> !led_o && res_valid_o && (res_code_o == OUT_EARLY));
endmodule

// File: tb/tb_reaction_tester.sv
module tb_reaction_tester;
  localparam int PRE = 2, DIV = 4, T = PRE * DIV;
  localparam int MINW = 20, SPAN = 41, TO = 30, PAUSE = 10;

  logic clk = 1'b0, rst_n = 1'b0, button_n = 1'b1, ready = 1'b0;
  logic led, valid;
  logic [1:0]  code;
  logic [15:0] ms;

  always #2.5 clk = ~clk;

  reaction_tester #(.PRESCALE(PRE), .DIVIDE(DIV), .MIN_MS(MINW), .SPAN_MS(SPAN),
                    .TIMEOUT_MS(TO), .PAUSE_MS(PAUSE), .MS_W(16)) dut (
    .clk_i(clk), .rst_ni(rst_n), .button_ni(button_n), .led_o(led),
    .res_valid_o(valid), .res_ready_i(ready), .res_code_o(code), .res_ms_o(ms));

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, fails = 0;
  int ws = 0, cyc_a = 0;
  bit in_pause = 0;
  logic [15:0] m_lfsr = 16'hBEEF;

  localparam int M_HIT = 0, M_EARLY = 1, M_SLOW = 2, M_COLL = 3, M_HOLD = 4;

  function automatic logic [15:0] lfsr_next(logic [15:0] x);
    return x[0] ? ((x >> 1) ^ 16'hB400) : (x >> 1);
  endfunction

  function automatic int wait_of(logic [15:0] x);
    return MINW + (int'(x) % SPAN);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic wait_until(int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic press();
    button_n = 1'b0;
    @(negedge clk);
    button_n = 1'b1;
  endtask

  task automatic wait_led(int exp, string req, output int l);
    int n = 0;
    while (!led && !valid && n < 20000) begin @(negedge clk); n++; end
    l = cyc;
    check(led === 1'b1, req, int'(led), 1);
    check((cyc - exp <= 2) && (exp - cyc <= 2), req, cyc, exp);
    check(valid === 1'b0, req, int'(valid), 0);
  endtask

  task automatic take_result(int exp_code, int exp_ms, string req);
    int n = 0;
    int d;
    logic [1:0] c0;
    logic [15:0] m0;
    while (!valid && n < 20000) begin @(negedge clk); n++; end
    check(valid === 1'b1, req, int'(valid), 1);
    check(int'(code) == exp_code, req, int'(code), exp_code);
    check(int'(ms) == exp_ms, req, int'(ms), exp_ms);
    check(led === 1'b0, req, int'(led), 0);
    c0 = code; m0 = ms;
    d = int'($urandom % 4);
    for (int i = 0; i < d; i++) begin
      if (i == 0) press(); else @(negedge clk);
      check(valid === 1'b1 && code == c0 && ms == m0, "R8 hold", int'(ms), int'(m0));
    end
    ready = 1'b1;
    @(negedge clk);
    ready = 1'b0;
    cyc_a = cyc;
    check(valid === 1'b0, "R8 accept", int'(valid), 0);
    ws = cyc_a + PAUSE * T + 18;
    in_pause = 1;
  endtask

  task automatic run_round(int mode, int k_in, bit poke);
    int w, l, k;
    string rq;
    k = k_in;
    m_lfsr = lfsr_next(m_lfsr);
    w = wait_of(m_lfsr);
    rq = in_pause ? "R9 pause+R3 wait" : "R2/R3 wait";
    if (mode == M_EARLY) begin
      if (k >= w) k = w - 1;
      wait_until(ws + k * T + 4);
      check(led === 1'b0, "R4", int'(led), 0);
      press();
      take_result(1, k, "R4 false start");
      return;
    end
    if (mode == M_HOLD) button_n = 1'b0;
    else if (poke && in_pause) begin
      wait_until(cyc_a + 2 * T);
      press();
    end
    wait_led(ws + w * T + 1, rq, l);
    case (mode)
      M_HIT: begin
        wait_until(l + k * T + 4);
        press();
        take_result(0, k, "R5 reaction");
      end
      M_SLOW: begin
        int n = 0;
        while (!valid && n < 20000) begin @(negedge clk); n++; end
        check(cyc == l + TO * T + 1, "R6 timeout cycle", cyc, l + TO * T + 1);
        check(cyc - l >= TO * T, "R1 ms length", cyc - l, TO * T + 1);
        take_result(2, TO, "R6 too slow");
      end
      M_COLL: begin
        wait_until(l + TO * T);
        press();
        take_result(0, TO, "R7 collision");
      end
      default: begin
        if (k < 3) k = 3;
        wait_until(l + T + 4);
        check(valid === 1'b0 && led === 1'b1, "R11 held low", int'(led), 1);
        button_n = 1'b1;
        wait_until(l + k * T + 4);
        press();
        take_result(0, k, "R11 edge only");
      end
    endcase
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    button_n = 1'b1;
    ready = 1'b0;
    repeat (3) @(negedge clk);
    check(led === 1'b0, "R10 reset led", int'(led), 0);
    check(valid === 1'b0, "R10 reset valid", int'(valid), 0);
    rst_n = 1'b1;
    ws = cyc + 17;
    m_lfsr = 16'hBEEF;
    in_pause = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd7321));
    do_reset();
    run_round(M_HIT, 5, 0);     // R2 first draw from seed
    run_round(M_EARLY, 3, 0);
    run_round(M_SLOW, 0, 0);
    run_round(M_COLL, 0, 1);
    run_round(M_HOLD, 6, 0);
    run_round(M_HIT, 0, 1);
    run_round(M_EARLY, 0, 0);
    run_round(M_HIT, TO - 1, 0);
    for (int r = 0; r < 14; r++) begin
      int md = int'($urandom % 5);
      int kk = (md == M_EARLY) ? int'($urandom % 60) : int'($urandom % TO);
      run_round(md, kk, bit'($urandom % 2));
    end
    do_reset();                  // R2 seed restored by reset
    run_round(M_HIT, 2, 0);
    run_round(M_EARLY, 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule